// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. Each clock it presents a trial code to an external digital-to-analog converter and reads back one comparator bit that says whether the sampled input is at least as large as the trial level. It settles one bit of the answer per clock, starting from the most significant. When the last bit is settled it raises a completion flag and copies the final code into a separate result register.

A level-sensitive start input controls the block. While start is high the trial register is held at zero and nothing advances. Releasing start begins a conversion on the next rising edge. Wiring the completion flag back to start makes the block convert continuously. In that mode each completion clears the register for one clock and a new conversion then begins on its own. The result register keeps the last finished code while the next conversion runs, so a reader always sees a complete value.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While `start` is high at a rising edge, that edge sets `trial_code` to 0 and `done` to 0, and no conversion advances.
- R2: The first rising edge that samples `start` low after it was high (or after reset) sets `trial_code` to a value with only its most significant bit (bit WIDTH-1) set, which is 8'h80 at the default width.
- R3: `cmp_ge` is 1 when the input level is greater than or equal to the level of the current `trial_code`. On a resolving edge the bit under test is cleared if `cmp_ge` is 0 and kept if it is 1.
- R4: Each resolving edge also sets the next lower bit. After edge k of a conversion (k = 1..WIDTH), `trial_code` holds the settled upper bits followed by a 1 at bit WIDTH-k and zeros below it.
- R5: `done` rises on edge WIDTH+1 after `start` is released, which is the edge that settles bit 0. It then stays high, with `trial_code` holding the final code, for as long as `start` stays low.
- R6: On the edge where `done` rises, `result` loads the final code. With an ideal comparator this code equals the input value.
- R7: `result` changes only on the edge where `done` rises. It keeps its value while a later conversion runs and when `start` aborts a conversion partway through.
- R8: With `start` driven by `done`, conversions repeat without outside help. `done` is high for exactly one clock, and consecutive rises are WIDTH+2 clocks apart.
- R9: While `rst_n` is low, `trial_code`, `done` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Level hold: high clears and holds, low lets a conversion run |
| cmp_ge | input | 1 | Comparator result: 1 when input level >= trial level |
| trial_code | output | WIDTH | Code driven to the external DAC |
| done | output | 1 | Conversion complete; high once bit 0 is settled |
| result | output | WIDTH | Last completed conversion code |

## Verification
Counting from the first rising edge that samples `start` low, `trial_code` shows its edge-k value k edges later. `done` and `result` both update on edge WIDTH+1, and in feedback mode the next `done` arrives WIDTH+2 edges after the previous one. The bench drives its inputs on falling edges and samples each output on the falling edge right after the rising edge where that output is due. Expected codes go into a queue when a conversion is launched. A monitor pops one entry each time `done` rises, and a rise that finds the queue empty is reported as a failure.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CONV = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_e;

  function automatic logic [31:0] top_bit_mask(input int unsigned width);
    return 32'd1 << (width - 1);
  endfunction

endpackage

// File: rtl/sar_rst_sync.sv
`timescale 1ns/1ps
module sar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/sar_sequencer.sv
`timescale 1ns/1ps
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [WIDTH-1:0] probe,
  output logic             arm,
  output logic             step,
  output logic             last,
  output logic             done
);

  localparam logic [WIDTH-1:0] MSB_MASK = {1'b1, {(WIDTH-1){1'b0}}};

  seq_state_e       state_q, state_d;
  logic [WIDTH-1:0] probe_q, probe_d;
  logic             done_q, done_d;
  logic             seq_en;

  always_comb begin
    state_d = state_q;
    probe_d = probe_q;
    done_d  = done_q;
    if (start) begin
      state_d = SEQ_IDLE;
      probe_d = '0;
      done_d  = 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          state_d = SEQ_CONV;
          probe_d = MSB_MASK;
        end
        SEQ_CONV: begin
          if (probe_q[0]) begin
            state_d = SEQ_HOLD;
            probe_d = '0;
            done_d  = 1'b1;
          end else begin
            probe_d = probe_q >> 1;
          end
        end
        SEQ_HOLD: begin
          state_d = SEQ_HOLD;
        end
        default: begin
          state_d = SEQ_IDLE;
          probe_d = '0;
        end
      endcase
    end
  end

  assign seq_en = start || (state_q != SEQ_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      probe_q <= '0;
      done_q  <= 1'b0;
    end else if (seq_en) begin
      state_q <= state_d;
      probe_q <= probe_d;
      done_q  <= done_d;
    end
  end

  assign probe = probe_q;
  assign arm   = !start && (state_q == SEQ_IDLE);
  assign step  = !start && (state_q == SEQ_CONV);
  assign last  = step && probe_q[0];
  assign done  = done_q;

endmodule

// File: rtl/sar_code_reg.sv
`timescale 1ns/1ps
module sar_code_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             arm,
  input  logic             step,
  input  logic             cmp_ge,
  input  logic [WIDTH-1:0] probe,
  output logic [WIDTH-1:0] code,
  output logic [WIDTH-1:0] settled
);

  localparam logic [WIDTH-1:0] MSB_MASK = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] code_q, code_d;
  logic             code_en;

  // bit under test is dropped when the trial level is above the input
  always_comb begin
    settled = cmp_ge ? code_q : (code_q & ~probe);
  end

  always_comb begin
    code_d = code_q;
    if (start)     code_d = '0;
    else if (arm)  code_d = MSB_MASK;
    else if (step) code_d = settled | (probe >> 1);
  end

  assign code_en = start || arm || step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign code = code_q;

endmodule

// File: rtl/sar_result_latch.sv
`timescale 1ns/1ps
module sar_result_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = load ? din : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (load) hold_q <= hold_d;
  end

  assign dout = hold_q;

endmodule

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
module sar_conv_ctrl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_ge,
  output logic [WIDTH-1:0] trial_code,
  output logic             done,
  output logic [WIDTH-1:0] result
);

  logic             rst_sync_n;
  logic [WIDTH-1:0] probe;
  logic             seq_arm;
  logic             seq_step;
  logic             seq_last;
  logic [WIDTH-1:0] settled_code;

  sar_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  sar_sequencer #(.WIDTH(WIDTH)) u_seq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (start),
    .probe (probe),
    .arm   (seq_arm),
    .step  (seq_step),
    .last  (seq_last),
    .done  (done)
  );

  sar_code_reg #(.WIDTH(WIDTH)) u_code (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .arm     (seq_arm),
    .step    (seq_step),
    .cmp_ge  (cmp_ge),
    .probe   (probe),
    .code    (trial_code),
    .settled (settled_code)
  );

  sar_result_latch #(.WIDTH(WIDTH)) u_res (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (seq_last),
    .din   (settled_code),
    .dout  (result)
  );

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
`timescale 1ns/1ps
module sar_conv_ctrl_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             cmp_ge,
  input logic [WIDTH-1:0] trial_code,
  input logic             done,
  input logic [WIDTH-1:0] result,
  input logic [WIDTH-1:0] probe,
  input logic             step
);

  localparam logic [WIDTH-1:0] MSB_MASK = {1'b1, {(WIDTH-1){1'b0}}};
  localparam int unsigned CW = $clog2(WIDTH + 2);
  localparam logic [CW-1:0] DONE_AT = CW'(WIDTH + 1);

  logic [CW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_q <= '0;
    else if (start)             since_q <= '0;
    else if (since_q < DONE_AT) since_q <= since_q + 1'b1;
  end

  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (trial_code == '0) && !done);

  a_r2_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start) && !start) |=> (trial_code == MSB_MASK));

  a_r3_clear_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cmp_ge) |=> ((trial_code & $past(probe)) == '0));

  a_r3_keep_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cmp_ge) |=> ((trial_code & $past(probe)) != '0));

  a_r4_single_probe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe));

  a_r5_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done == (since_q == DONE_AT));

  a_r6_result_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (result == trial_code));

  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> $stable(result));

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start      (start),
  .cmp_ge     (cmp_ge),
  .trial_code (trial_code),
  .done       (done),
  .result     (result),
  .probe      (probe),
  .step       (seq_step)
);

// File: tb/tb_sar_conv_ctrl.sv
`timescale 1ns/1ps
module tb_sar_conv_ctrl;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         start_drv;
  logic         loop_mode;
  logic         start;
  logic         cmp_ge;
  logic [W-1:0] vin;
  logic [W-1:0] trial_code;
  logic         done;
  logic [W-1:0] result;

  int checks;
  int errors;
  int cyc;
  logic [W-1:0] exp_q[$];
  logic done_prev;

  // ideal external DAC + comparator
  assign cmp_ge = (vin >= trial_code);
  assign start  = loop_mode ? done : start_drv;

  sar_conv_ctrl #(.WIDTH(W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmp_ge     (cmp_ge),
    .trial_code (trial_code),
    .done       (done),
    .result     (result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] trial_after(input logic [W-1:0] v, input int k);
    logic [W-1:0] low_mask;
    if (k > W) return v;
    low_mask = (W'(1) << (W - k + 1)) - W'(1);
    return (v & ~low_mask) | (W'(1) << (W - k));
  endfunction

  // monitor: each rise of done pops one expected code
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !done_prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected done", int'(result), 0);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(result == e, "R6 result", int'(result), int'(e));
          chk(trial_code == e, "R5 final trial", int'(trial_code), int'(e));
        end
      end
      done_prev <= done;
    end else begin
      done_prev <= 1'b0;
    end
  end

  task automatic convert(input logic [W-1:0] v, input bit trace);
    logic [W-1:0] prev_res;
    prev_res = result;
    vin = v;
    start_drv = 1'b0;
    exp_q.push_back(v);
    for (int k = 1; k <= W + 1; k++) begin
      @(negedge clk);
      if (trace) chk(trial_code == trial_after(v, k), (k == 1) ? "R2 msb first" : "R4/R3 trial",
                     int'(trial_code), int'(trial_after(v, k)));
      chk(done == (k == W + 1), "R5 done timing", int'(done), int'(k == W + 1));
      if (k <= W) chk(result == prev_res, "R7 result held", int'(result), int'(prev_res));
    end
    @(negedge clk);
    chk(done && trial_code == v, "R5 done holds", int'(trial_code), int'(v));
    start_drv = 1'b1;
    @(negedge clk);
    chk(!done && trial_code == '0, "R1 start clears", int'(trial_code), 0);
  endtask

  initial begin
    checks = 0; errors = 0; cyc = 0;
    rst_n = 1'b0; start_drv = 1'b1; loop_mode = 1'b0; vin = '0;
    repeat (3) @(negedge clk);
    chk(trial_code == '0 && !done && result == '0, "R9 reset state", int'(trial_code), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(trial_code == '0 && !done, "R1 held by start", int'(trial_code), 0);

    convert(8'h5A, 1'b1);
    convert(8'h00, 1'b1);
    convert(8'hFF, 1'b1);
    convert(8'h80, 1'b1);
    convert(8'h7F, 1'b1);
    convert(8'h01, 1'b0);
    convert(8'hA5, 1'b1);

    // R1/R7: abort partway through
    begin
      logic [W-1:0] held;
      held = result;
      vin = 8'h33;
      start_drv = 1'b0;
      repeat (4) @(negedge clk);
      start_drv = 1'b1;
      @(negedge clk);
      chk(trial_code == '0 && !done, "R1 abort clears", int'(trial_code), 0);
      repeat (12) @(negedge clk);
      chk(trial_code == '0 && !done, "R1 no progress", int'(trial_code), 0);
      chk(result == held, "R7 abort keeps result", int'(result), int'(held));
    end

    // R8: done fed back to start
    begin
      int stamp[3];
      vin = 8'hC3;
      for (int i = 0; i < 3; i++) exp_q.push_back(8'hC3);
      loop_mode = 1'b1;
      for (int i = 0; i < 3; i++) begin
        do @(negedge clk); while (!done);
        stamp[i] = cyc;
        if (i == 2) begin
          start_drv = 1'b1;
          loop_mode = 1'b0;
        end
        @(negedge clk);
        chk(!done, "R8 one-cycle done", int'(done), 0);
      end
      chk(stamp[1] - stamp[0] == W + 2, "R8 period", stamp[1] - stamp[0], W + 2);
      chk(stamp[2] - stamp[1] == W + 2, "R8 period", stamp[2] - stamp[1], W + 2);
      chk(exp_q.size() == 0, "R8 all completions seen", exp_q.size(), 0);
    end

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule